// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block lets a host microcontroller configure and monitor a three-channel line interface over a four-wire serial link. The wires are a select, a serial clock, a serial data input and a serial data output with a separate output enable. The output enable lets a pad driver float the output line when the block is not sending. Each transfer is one 16-clock frame that either writes one 8-bit register or reads one back.

The register space holds eight slots per channel. Slot 0 of each channel is a read-only image of that channel's live alarm inputs. Slot 1 holds the transmit controls and slot 4 holds the loopback and rate controls. Both drive configuration outputs directly. Every other slot, and every slot of the fourth channel position, reads as zero and ignores writes. The serial pins are sampled with the fast system clock, so the serial clock must run well below it. A separate register-reset input returns all control fields to zero without touching the serial logic.

Top module: `lcfg_serial_regs`

## Requirements
- R1: A frame runs while `csel` is high. It is sampled on 16 rising edges of `sclk`, in this order: the direction bit (0 = write, 1 = read), address bits A0 to A5 least significant first, one turnaround bit, then data bits D0 to D7 least significant first. `sclk` idles low.
- R2: Address bits A4..A3 select the channel and A2..A0 select the slot. A frame with A5 = 1 writes nothing and reads back zero.
- R3: Slot 0 is read-only. It holds bit0 = drive monitor, bit1 = digital LOS, bit2 = analog LOS, bit3 = receive LOS and bit4 = loss of lock, with bits 7..5 reading zero. The value returned is the one present on `stat_i` at the turnaround bit.
- R4: Slot 1 bits 4..0 drive `tx_ctrl_o[5c+4:5c]` for channel c: bit0 binary input, bit1 line level, bit2 clock invert, bit3 all-ones, bit4 transmit off. Bits 7..5 read zero.
- R5: Slot 4 bits 3..0 drive `mode_o[4c+3:4c]`: bit0 remote loopback, bit1 local loopback, bit2 E3 rate, bit3 STS-1 rate. Bits 7..4 read zero.
- R6: Writes to slot 0, to slots 2, 3, 5, 6 and 7, and to channel code 3 change no output. Reads of the unused slots and of channel code 3 return zero.
- R7: During a read, D0 leaves on the falling `sclk` edge after the turnaround rising edge, and each later falling edge shifts out the next bit. `sdo_oe` is high only over those eight data bits while `csel` is high. Otherwise `sdo_oe` and `sdo` are 0.
- R8: Dropping `csel` before the 16th rising edge abandons the frame without a register update, and the next frame starts from its first bit.
- R9: A high `reg_rst` clears every control field to zero on the next clock edge. Status reads are unaffected.
- R10: Control outputs change only on a completed write frame, `reg_rst` or `rst`.
- R11: Synchronous `rst` clears all control fields and the frame state, and leaves `sdo_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| reg_rst | input | 1 | Clears all control fields |
| csel | input | 1 | Serial select, high for the length of a frame |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| stat_i | input | 15 | Live alarms, 5 per channel, channel c at [5c+4:5c] |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for the serial data output |
| tx_ctrl_o | output | 15 | Transmit controls, 5 per channel |
| mode_o | output | 12 | Loopback and rate controls, 4 per channel |

## Verification
The serial pins pass through one register and an edge detector, so each `sclk` edge acts on the state two system cycles after the pin moves. A completed write shows on the control outputs three cycles after the final rising `sclk`, and `sdo`/`sdo_oe` settle two cycles after a falling edge. The bench holds every `sclk` level for six system cycles. It reads `sdo` just before it raises the next rising edge, and it compares the control outputs only after the frame has closed and several idle cycles have passed. This leaves a margin on every path rather than sampling on the exact settling cycle.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;

    // frame geometry (direction bit, address, turnaround, data)
    localparam int ADDR_BITS   = 6;
    localparam int DATA_BITS   = 8;
    localparam int SLOTS_PER_CH = 8;

    // slot numbers that hold storage or status
    localparam int SLOT_STAT = 0;
    localparam int SLOT_TXC  = 1;
    localparam int SLOT_MODE = 4;

    // live alarm image, bit 0 is the drive monitor
    typedef struct packed {
        logic rx_lol;
        logic rx_los;
        logic ana_los;
        logic dig_los;
        logic drive_mon;
    } stat_t;

    // transmit controls
    typedef struct packed {
        logic tx_off;
        logic all_ones;
        logic clk_inv;
        logic level;
        logic binary;
    } txc_t;

    // loopback and rate controls
    typedef struct packed {
        logic sts1;
        logic e3;
        logic local_lb;
        logic remote_lb;
    } mode_t;

    localparam int STAT_W = $bits(stat_t);
    localparam int TXC_W  = $bits(txc_t);
    localparam int MODE_W = $bits(mode_t);

    function automatic int frame_len(input int aw, input int dw);
        return 1 + aw + 1 + dw;
    endfunction

endpackage

// File: rtl/lcfg_frame.sv
module lcfg_frame import lcfg_pkg::*; #(
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = DATA_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csel,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int FRAME_BITS = frame_len(ADDR_W, DATA_W);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_TURN     = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] C_END      = CNT_W'(FRAME_BITS);

    logic              cs_q, sclk_q, sclk_qq, sdi_q;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-2:0] data_q;
    logic [DATA_W-1:0] rd_sh;
    logic              rise, fall;

    assign rise    = cs_q &  sclk_q & ~sclk_qq;
    assign fall    = cs_q & ~sclk_q &  sclk_qq;
    assign rd_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b0;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            sdi_q   <= 1'b0;
            cnt     <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_sh   <= '0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            cs_q    <= csel;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            sdi_q   <= sdi;
            wr_stb  <= 1'b0;
            if (!cs_q) begin
                cnt    <= '0;
                sdo    <= 1'b0;
                sdo_oe <= 1'b0;
            end else begin
                if (rise && cnt < C_END) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == '0) begin
                        rw_q <= sdi_q;
                    end else if (cnt <= C_ADDR_END) begin
                        addr_q <= {sdi_q, addr_q[ADDR_W-1:1]};
                    end else if (cnt == C_TURN) begin
                        rd_sh <= rd_data;
                    end else begin
                        data_q <= {sdi_q, data_q[DATA_W-2:1]};
                        if (cnt == C_LAST && !rw_q && !addr_q[ADDR_W-1]) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= addr_q;
                            wr_data <= {sdi_q, data_q};
                        end
                    end
                end
                if (fall) begin
                    if (rw_q && cnt > C_TURN && cnt <= C_LAST) begin
                        sdo    <= rd_sh[0];
                        rd_sh  <= rd_sh >> 1;
                        sdo_oe <= 1'b1;
                    end else begin
                        sdo    <= 1'b0;
                        sdo_oe <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lcfg_regbank.sv
module lcfg_regbank import lcfg_pkg::*; #(
    parameter int NCH    = 3,
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = DATA_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_rst,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [NCH*STAT_W-1:0] stat_i,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NCH*TXC_W-1:0]  tx_ctrl_o,
    output logic [NCH*MODE_W-1:0] mode_o
);
    localparam int SLOT_W = $clog2(SLOTS_PER_CH);
    localparam int CH_W   = ADDR_W - 1 - SLOT_W;

    txc_t  txc_arr  [NCH];
    mode_t mode_arr [NCH];
    logic  unused_bits;

    assign unused_bits = ^wr_data[DATA_W-1:TXC_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        txc_t  txc_r;
        mode_t mode_r;
        logic  hit;

        assign hit = wr_stb && !wr_addr[ADDR_W-1] &&
                     (wr_addr[SLOT_W +: CH_W] == CH_W'(c));

        always_ff @(posedge clk) begin
            if (rst || reg_rst) begin
                txc_r  <= '0;
                mode_r <= '0;
            end else if (hit) begin
                if (wr_addr[SLOT_W-1:0] == SLOT_W'(SLOT_TXC))
                    txc_r <= wr_data[TXC_W-1:0];
                else if (wr_addr[SLOT_W-1:0] == SLOT_W'(SLOT_MODE))
                    mode_r <= wr_data[MODE_W-1:0];
            end
        end

        assign txc_arr[c]  = txc_r;
        assign mode_arr[c] = mode_r;
        assign tx_ctrl_o[c*TXC_W +: TXC_W]  = txc_r;
        assign mode_o[c*MODE_W +: MODE_W]   = mode_r;
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (!rd_addr[ADDR_W-1] && rd_addr[SLOT_W +: CH_W] == CH_W'(c)) begin
                if (rd_addr[SLOT_W-1:0] == SLOT_W'(SLOT_STAT))
                    rd_data = DATA_W'(stat_i[c*STAT_W +: STAT_W]);
                else if (rd_addr[SLOT_W-1:0] == SLOT_W'(SLOT_TXC))
                    rd_data = DATA_W'(txc_arr[c]);
                else if (rd_addr[SLOT_W-1:0] == SLOT_W'(SLOT_MODE))
                    rd_data = DATA_W'(mode_arr[c]);
            end
        end
    end
endmodule

// File: rtl/lcfg_serial_regs.sv
module lcfg_serial_regs import lcfg_pkg::*; #(
    parameter int NCH    = 3,
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = DATA_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_rst,
    input  logic                  csel,
    input  logic                  sclk,
    input  logic                  sdi,
    input  logic [NCH*STAT_W-1:0] stat_i,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [NCH*TXC_W-1:0]  tx_ctrl_o,
    output logic [NCH*MODE_W-1:0] mode_o
);
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    lcfg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .csel    (csel),
        .sclk    (sclk),
        .sdi     (sdi),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    lcfg_regbank #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .reg_rst   (reg_rst),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .stat_i    (stat_i),
        .rd_data   (rd_data),
        .tx_ctrl_o (tx_ctrl_o),
        .mode_o    (mode_o)
    );
endmodule

// File: rtl/lcfg_serial_regs_chk.sv
module lcfg_serial_regs_chk import lcfg_pkg::*; #(
    parameter int NCH = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_rst,
    input logic                  csel,
    input logic                  sdo,
    input logic                  sdo_oe,
    input logic [NCH*TXC_W-1:0]  tx_ctrl_o,
    input logic [NCH*MODE_W-1:0] mode_o,
    input logic                  wr_stb,
    input logic                  wr_a5
);
    // R7
    oe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> $past(csel, 2));

    // R7
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

    // R9
    regrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rst |=> (tx_ctrl_o == '0 && mode_o == '0));

    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_stb) && !$past(reg_rst)) |->
            ($stable(tx_ctrl_o) && $stable(mode_o)));

    // R2
    a5_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !wr_a5);

    // R11
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sdo_oe && tx_ctrl_o == '0 && mode_o == '0));
endmodule

bind lcfg_serial_regs lcfg_serial_regs_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rst   (reg_rst),
    .csel      (csel),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .tx_ctrl_o (tx_ctrl_o),
    .mode_o    (mode_o),
    .wr_stb    (wr_stb),
    .wr_a5     (wr_addr[ADDR_W-1])
);

// File: tb/lcfg_serial_regs_tb.sv
module lcfg_serial_regs_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_rst = 1'b0;
    logic        csel = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [14:0] stat_i = '0;
    logic        sdo, sdo_oe;
    logic [14:0] tx_ctrl_o;
    logic [11:0] mode_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [4:0] tx_m [3];
    logic [3:0] md_m [3];

    always #5 clk = ~clk;

    lcfg_serial_regs u_dut (
        .clk(clk), .rst(rst), .reg_rst(reg_rst), .csel(csel), .sclk(sclk),
        .sdi(sdi), .stat_i(stat_i), .sdo(sdo), .sdo_oe(sdo_oe),
        .tx_ctrl_o(tx_ctrl_o), .mode_o(mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        int ch = int'(a[4:3]);
        if (a[5] || ch >= 3) return 8'h00;
        case (a[2:0])
            3'd0: return {3'b0, stat_i[ch*5 +: 5]};
            3'd1: return {3'b0, tx_m[ch]};
            3'd4: return {4'b0, md_m[ch]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(input logic [5:0] a, input logic [7:0] d);
        int ch = int'(a[4:3]);
        if (!a[5] && ch < 3) begin
            if (a[2:0] == 3'd1) tx_m[ch] = d[4:0];
            if (a[2:0] == 3'd4) md_m[ch] = d[3:0];
        end
    endtask

    task automatic check_outs(input string req);
        for (int c = 0; c < 3; c++) begin
            check(req, int'(tx_ctrl_o[c*5 +: 5]), int'(tx_m[c]));
            check(req, int'(mode_o[c*4 +: 4]), int'(md_m[c]));
        end
    endtask

    // one frame; abort_at < 16 drops csel before that bit
    task automatic frame(input logic rw, input logic [5:0] a, input logic [7:0] d,
                         input int abort_at, output logic [7:0] rd, output int oe_bad);
        rd = '0;
        oe_bad = 0;
        @(negedge clk);
        csel = 1'b1;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            if (k == abort_at) break;
            if (k == 0)      sdi = rw;
            else if (k <= 6) sdi = a[k-1];
            else if (k == 7) sdi = 1'b0;
            else             sdi = rw ? 1'b0 : d[k-8];
            repeat (HALF) @(negedge clk);
            if (rw && k >= 8) begin
                if (sdo_oe !== 1'b1) oe_bad++;
                rd[k-8] = sdo;
            end else if (sdo_oe !== 1'b0) begin
                oe_bad++;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csel = 1'b0;
        sdi  = 1'b0;
        repeat (2*HALF) @(negedge clk);
        if (sdo_oe !== 1'b0) oe_bad++;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] rd;
        int ob;
        frame(1'b0, a, d, 16, rd, ob);
        model_wr(a, d);
        check("R7 write oe", ob, 0);
    endtask

    task automatic do_read(input string req, input logic [5:0] a);
        logic [7:0] rd;
        logic [7:0] ex;
        int ob;
        ex = exp_rd(a);
        frame(1'b1, a, 8'h00, 16, rd, ob);
        check(req, int'(rd), int'(ex));
        check("R7 read oe", ob, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        int ob;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) begin tx_m[c] = '0; md_m[c] = '0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11 reset state
        check("R11 oe", int'(sdo_oe), 0);
        check("R11 sdo", int'(sdo), 0);
        check_outs("R11 ctrl");

        // R1 R4 write/readback, upper bits dropped
        do_write(6'h09, 8'h1F);
        check_outs("R4 ch1 tx");
        do_read("R1 R4 readback", 6'h09);
        do_write(6'h09, 8'hE5);
        do_read("R4 upper zero", 6'h09);

        // R5
        do_write(6'h14, 8'hAA);
        check_outs("R5 ch2 mode");
        do_read("R5 readback", 6'h14);

        // R3 status patterns
        stat_i = 15'h7FFF; do_read("R3 ch0 all", 6'h00);
        stat_i = 15'h0155; do_read("R3 ch1", 6'h08);
        stat_i = 15'h5A00; do_read("R3 ch2", 6'h10);

        // R6 read-only and unused slots
        do_write(6'h00, 8'hFF);
        check_outs("R6 slot0 write");
        do_read("R6 slot0 unchanged", 6'h00);
        do_write(6'h0D, 8'hFF);
        check_outs("R6 slot5 write");
        do_read("R6 slot5 zero", 6'h0D);
        do_write(6'h19, 8'h1F);
        check_outs("R6 ch3 write");
        do_read("R6 ch3 zero", 6'h19);

        // R2 A5 set
        frame(1'b0, 6'h21, 8'h15, 16, rd, ob);
        check_outs("R2 A5 write ignored");
        do_read("R2 A5 read zero", 6'h21);

        // R8 abort mid-frame then clean frame
        frame(1'b0, 6'h01, 8'h0A, 12, rd, ob);
        check_outs("R8 abort no update");
        do_write(6'h01, 8'h0B);
        check_outs("R8 next frame");

        // R9 register reset
        @(negedge clk); reg_rst = 1'b1;
        @(negedge clk); reg_rst = 1'b0;
        for (int c = 0; c < 3; c++) begin tx_m[c] = '0; md_m[c] = '0; end
        repeat (2) @(negedge clk);
        check_outs("R9 cleared");
        stat_i = 15'h2A1C;
        do_read("R9 status intact", 6'h08);

        // random mix
        for (int i = 0; i < 160; i++) begin
            logic rw;
            logic [5:0] a;
            logic [7:0] d;
            int ab;
            rw = 1'($urandom % 2);
            if ($urandom % 2 == 0) begin
                int r = $urandom % 3;
                a = {1'b0, 2'($urandom % 3), (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : 3'd4};
            end else begin
                a = 6'($urandom);
            end
            d = 8'($urandom);
            stat_i = 15'($urandom);
            ab = ($urandom % 10 == 0) ? 1 + int'($urandom % 15) : 16;
            if (ab < 16) begin
                frame(rw, a, d, ab, rd, ob);
                check_outs("R8 random abort");
            end else if (rw) begin
                do_read("R1 R3 random read", a);
                check_outs("R10 read no change");
            end else begin
                do_write(a, d);
                check_outs("R2 R6 random write");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule